// File: doc/BRIEF.md
# Receive FIFO Unload Port for Eight UART Channels

This block sits between the receive FIFOs of eight UART channels and a 32-bit host read bus. Each channel owns a 64-entry receive FIFO that a serializer fills one entry per cycle; an entry is a data byte plus three error flags (parity, framing, break). The host reads bytes out through memory-mapped windows. One access can drain one to four bytes at once, chosen by the byte enables, so a driver can unload a full FIFO with a short burst of dword reads instead of 64 byte reads.

A second window per channel returns each data byte side by side with a status byte built from that byte's own error flags and a data-ready bit. A driver using it never has to read a separate line-status register to learn which byte was damaged. All bytes consumed by an access leave the FIFO on the clock edge that samples the read strobe. The read data comes back one cycle later.

Top module: `rx_unload_port`

## Requirements
- R1: Channel N is decoded when address bits 11:9 equal N and bit 8 is 1, which gives a base of 0x(2N+1)00. Offsets 0x00–0x3F form the data window and offsets 0x80–0xFF form the paired window. Any offset in either window behaves the same way.
- R2: A data-window read pops one byte per asserted byte enable, up to the FIFO occupancy. Popped bytes fill the enabled lanes in ascending lane order, with the oldest byte in the lowest enabled lane.
- R3: In the data window, an enabled lane for which no byte is left returns 0x00 and does not reduce the occupancy.
- R4: A paired-window read treats lanes 1:0 as pair 0 and lanes 3:2 as pair 1. A pair is requested when either of its byte enables is set, and each requested pair pops one byte, pair 0 first. The low lane of a pair holds the data byte. The high lane holds the status byte: bit 0 data-ready, bit 1 parity error, bit 2 framing error, bit 3 break, bits 7:4 zero.
- R5: A requested pair for which no byte is left returns 0x0000, so its data-ready bit is clear, and nothing is popped for it.
- R6: Lanes that are not enabled (data window) or pairs that are not requested (paired window) return zero.
- R7: A read with address bit 8 clear, or with an offset in 0x40–0x7F, returns zero and pops nothing.
- R8: The read data and a one-cycle rd_valid pulse appear in the cycle after the strobe. The per-channel occupancy on rx_level drops on that same edge by the number of bytes popped.
- R9: Each FIFO holds 64 entries. A push arriving while occupancy is 64 is dropped. A push and a pop on the same edge both take effect.
- R10: A full FIFO drains in order with 16 consecutive dword reads with all enables set, leaving occupancy 0.
- R11: After reset, every FIFO is empty, rd_data is zero and rd_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 8 | Per-channel push strobe from the serializers |
| rx_byte | input | 64 | Per-channel received byte, channel c at bits 8c+7:8c |
| rx_err | input | 24 | Per-channel error flags, channel c at bits 3c+2:3c (bit 0 parity, 1 framing, 2 break) |
| rd_strobe | input | 1 | Host read strobe |
| rd_addr | input | 12 | Host read address |
| rd_be | input | 4 | Byte enables of the read |
| rd_data | output | 32 | Read return data |
| rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| rx_level | output | 56 | Per-channel occupancy, channel c at bits 7c+6:7c |

## Verification
A read or write pointer that slips shows up at the next read of that channel as wrong or reordered bytes on rd_data, one cycle after the strobe. A wrong occupancy count shows on rx_level on the very edge it happens. It also shows later as a lane returning data where zero was expected, or the reverse. A packer that miscounts enables or pairs leaves a mismatch between the bytes returned and the drop in rx_level in the same cycle. Errors in the paired status encoding show as wrong high-lane bits on the first paired read of a byte that carries flags.

// File: rtl/rx_unload_pkg.sv
package rx_unload_pkg;

    // One stored receive entry: error flags above the data byte.
    // err[0] parity, err[1] framing, err[2] break.
    typedef struct packed {
        logic [2:0] err;
        logic [7:0] data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_DATA = 2'd1,
        WIN_PAIR = 2'd2
    } win_e;

    localparam int LANES = 4;

    // Status byte for the paired window: ready, parity, framing, break.
    function automatic logic [7:0] pair_status(rx_entry_t e);
        return {4'b0000, e.err[2], e.err[1], e.err[0], 1'b1};
    endfunction

endpackage

// File: rtl/rx_fifo_multipop.sv
module rx_fifo_multipop
    import rx_unload_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int PEEK  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int POP_W = $clog2(PEEK + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_i,
    input  rx_entry_t             push_entry_i,
    input  logic [POP_W-1:0]      pop_n_i,
    output rx_entry_t [PEEK-1:0]  peek_o,
    output logic [CNT_W-1:0]      level_o
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t  st_d, st_q;
    rx_entry_t mem [DEPTH];
    logic      push_ok;

    // Fullness is judged on the occupancy at the start of the cycle.
    always_comb begin
        push_ok   = push_i && (st_q.cnt != FULL_CNT);
        st_d      = st_q;
        st_d.wr   = st_q.wr + PTR_W'(push_ok);
        st_d.rd   = st_q.rd + PTR_W'(pop_n_i);
        st_d.cnt  = st_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_n_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[st_q.wr] <= push_entry_i;
        end
    end

    // The oldest PEEK entries are visible at once so several can leave per cycle.
    for (genvar i = 0; i < PEEK; i++) begin : g_peek
        assign peek_o[i] = mem[st_q.rd + PTR_W'(i)];
    end

    assign level_o = st_q.cnt;

    assert_pop_within_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(pop_n_i) <= st_q.cnt);

    assert_level_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);

    assert_full_push_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && st_q.cnt == FULL_CNT && pop_n_i == '0) |=> (st_q.cnt == FULL_CNT));

endmodule

// File: rtl/rx_window_decode.sv
module rx_window_decode
    import rx_unload_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CH_W   = $clog2(NCH),
    localparam int ADDR_W = 9 + CH_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [CH_W-1:0]   chan_o,
    output win_e              win_o
);

    // Channel field sits above the odd-page bit; bits 7:6 pick the window.
    always_comb begin
        chan_o = addr_i[ADDR_W-1:9];
        if (!addr_i[8]) begin
            win_o = WIN_NONE;
        end else if (addr_i[7]) begin
            win_o = WIN_PAIR;
        end else if (addr_i[6] == 1'b0) begin
            win_o = WIN_DATA;
        end else begin
            win_o = WIN_NONE;
        end
    end

endmodule

// File: rtl/rx_lane_pack.sv
module rx_lane_pack
    import rx_unload_pkg::*;
#(
    parameter int CNT_W = 7,
    localparam int POP_W = $clog2(LANES + 1)
) (
    input  win_e                   win_i,
    input  logic [LANES-1:0]       be_i,
    input  logic [CNT_W-1:0]       avail_i,
    input  rx_entry_t [LANES-1:0]  peek_i,
    output logic [8*LANES-1:0]     lanes_o,
    output logic [POP_W-1:0]       pop_o
);

    logic [POP_W-1:0] k;

    // A running index walks the peeked entries as lanes or pairs claim them.
    always_comb begin
        k       = '0;
        lanes_o = '0;
        unique case (win_i)
            WIN_DATA: begin
                for (int l = 0; l < LANES; l++) begin
                    if (be_i[l] && (CNT_W'(k) < avail_i)) begin
                        lanes_o[l*8 +: 8] = peek_i[k[1:0]].data;
                        k = k + POP_W'(1);
                    end
                end
            end
            WIN_PAIR: begin
                for (int p = 0; p < LANES/2; p++) begin
                    if ((be_i[2*p] | be_i[2*p+1]) && (CNT_W'(k) < avail_i)) begin
                        lanes_o[16*p +: 8]     = peek_i[k[1:0]].data;
                        lanes_o[16*p + 8 +: 8] = pair_status(peek_i[k[1:0]]);
                        k = k + POP_W'(1);
                    end
                end
            end
            default: ;
        endcase
        pop_o = k;
    end

endmodule

// File: rtl/rx_unload_port.sv
module rx_unload_port
    import rx_unload_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int DEPTH = 64,
    localparam int CH_W   = $clog2(NCH),
    localparam int ADDR_W = 9 + CH_W,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int POP_W  = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        rx_push,
    input  logic [NCH*8-1:0]      rx_byte,
    input  logic [NCH*3-1:0]      rx_err,
    input  logic                  rd_strobe,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [LANES-1:0]      rd_be,
    output logic [8*LANES-1:0]    rd_data,
    output logic                  rd_valid,
    output logic [NCH*CNT_W-1:0]  rx_level
);

    typedef struct packed {
        logic [8*LANES-1:0] data;
        logic               valid;
    } rsp_t;

    rsp_t                  rsp_d, rsp_q;
    logic [CH_W-1:0]       sel_ch;
    win_e                  win;
    logic [CNT_W-1:0]      lvl [NCH];
    rx_entry_t [LANES-1:0] peek_all [NCH];
    logic [POP_W-1:0]      ch_pop [NCH];
    logic [8*LANES-1:0]    packed_lanes;
    logic [POP_W-1:0]      pop_n;
    logic                  any_pop;

    rx_window_decode #(.NCH(NCH)) u_decode (
        .addr_i (rd_addr),
        .chan_o (sel_ch),
        .win_o  (win)
    );

    rx_lane_pack #(.CNT_W(CNT_W)) u_pack (
        .win_i   (rd_strobe ? win : WIN_NONE),
        .be_i    (rd_be),
        .avail_i (lvl[sel_ch]),
        .peek_i  (peek_all[sel_ch]),
        .lanes_o (packed_lanes),
        .pop_o   (pop_n)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        rx_entry_t entry_in;
        assign entry_in.data = rx_byte[c*8 +: 8];
        assign entry_in.err  = rx_err[c*3 +: 3];
        assign ch_pop[c]     = (sel_ch == CH_W'(c)) ? pop_n : '0;

        rx_fifo_multipop #(.DEPTH(DEPTH), .PEEK(LANES)) u_fifo (
            .clk          (clk),
            .rst_n        (rst_n),
            .push_i       (rx_push[c]),
            .push_entry_i (entry_in),
            .pop_n_i      (ch_pop[c]),
            .peek_o       (peek_all[c]),
            .level_o      (lvl[c])
        );

        assign rx_level[c*CNT_W +: CNT_W] = lvl[c];
    end

    always_comb begin
        any_pop = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            any_pop = any_pop | (ch_pop[c] != '0);
        end
    end

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = rd_strobe;
        rsp_d.data  = rd_strobe ? packed_lanes : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rd_data  = rsp_q.data;
    assign rd_valid = rsp_q.valid;

    assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> rd_valid);

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> !rd_valid);

    assert_miss_returns_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && win == WIN_NONE) |=> (rd_data == '0));

    assert_miss_no_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe || win == WIN_NONE) |-> !any_pop);

endmodule

// File: tb/rx_unload_port_test.sv
module rx_unload_port_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  rx_push;
    logic [63:0] rx_byte;
    logic [23:0] rx_err;
    logic        rd_strobe;
    logic [11:0] rd_addr;
    logic [3:0]  rd_be;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [55:0] rx_level;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // Reference model: circular buffers with {err, data} per entry.
    logic [10:0] mbuf [8][64];
    int          mhead [8];
    int          mcnt  [8];

    logic [31:0] exp_data;
    string       exp_tag;
    bit          pend = 0;

    always #2.5 clk = ~clk;

    rx_unload_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_push   (rx_push),
        .rx_byte   (rx_byte),
        .rx_err    (rx_err),
        .rd_strobe (rd_strobe),
        .rd_addr   (rd_addr),
        .rd_be     (rd_be),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .rx_level  (rx_level)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_pop(input int ch, output logic [10:0] e);
        e = mbuf[ch][mhead[ch]];
        mhead[ch] = (mhead[ch] + 1) % 64;
        mcnt[ch]--;
    endtask

    task automatic predict(input logic [11:0] a, input logic [3:0] b,
                           output logic [31:0] e, output string t);
        int ch;
        logic [10:0] ent;
        ch = int'(a[11:9]);
        e  = '0;
        if (!a[8] || (!a[7] && a[6])) begin
            t = "R7";
        end else if (a[7]) begin
            t = "R4";
            for (int p = 0; p < 2; p++) begin
                if ((b[2*p] | b[2*p+1]) && mcnt[ch] > 0) begin
                    model_pop(ch, ent);
                    e[16*p +: 8]     = ent[7:0];
                    e[16*p + 8 +: 8] = {4'b0000, ent[10], ent[9], ent[8], 1'b1};
                end
            end
        end else begin
            t = "R2";
            for (int l = 0; l < 4; l++) begin
                if (b[l] && mcnt[ch] > 0) begin
                    model_pop(ch, ent);
                    e[l*8 +: 8] = ent[7:0];
                end
            end
        end
    endtask

    // One clock of stimulus; checks the previous cycle's results first.
    task automatic step(input logic [7:0] pv, input logic [63:0] pd, input logic [23:0] pe,
                        input logic st, input logic [11:0] a, input logic [3:0] b,
                        input string tag);
        bit full [8];
        string t;
        @(negedge clk);
        if (pend) begin
            check(rd_valid == 1'b1, "R8", "rd_valid after strobe", 64'(rd_valid), 64'd1);
            check(rd_data == exp_data, exp_tag, "rd_data", 64'(rd_data), 64'(exp_data));
        end else begin
            check(rd_valid == 1'b0, "R8", "rd_valid idle", 64'(rd_valid), 64'd0);
        end
        for (int c = 0; c < 8; c++) begin
            check(rx_level[c*7 +: 7] == 7'(mcnt[c]), "R9", $sformatf("level ch%0d", c),
                  64'(rx_level[c*7 +: 7]), 64'(mcnt[c]));
        end
        rx_push   = pv;
        rx_byte   = pd;
        rx_err    = pe;
        rd_strobe = st;
        rd_addr   = a;
        rd_be     = b;
        for (int c = 0; c < 8; c++) full[c] = (mcnt[c] >= 64);
        if (st) begin
            predict(a, b, exp_data, t);
            exp_tag = (tag != "") ? tag : t;
        end
        for (int c = 0; c < 8; c++) begin
            if (pv[c] && !full[c]) begin
                mbuf[c][(mhead[c] + mcnt[c]) % 64] = {pe[c*3 +: 3], pd[c*8 +: 8]};
                mcnt[c]++;
            end
        end
        pend = st;
    endtask

    task automatic push1(input int ch, input logic [7:0] d, input logic [2:0] er);
        logic [63:0] pd;
        logic [23:0] pe;
        pd = '0;
        pe = '0;
        pd[ch*8 +: 8] = d;
        pe[ch*3 +: 3] = er;
        step(8'(1 << ch), pd, pe, 1'b0, 12'h0, 4'h0, "");
    endtask

    task automatic rd(input logic [11:0] a, input logic [3:0] b, input string tag);
        step(8'h00, 64'h0, 24'h0, 1'b1, a, b, tag);
    endtask

    task automatic idle();
        step(8'h00, 64'h0, 24'h0, 1'b0, 12'h0, 4'h0, "");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [11:0] a;
        logic [7:0]  pv;
        logic [63:0] pd;
        logic [23:0] pe;
        int ch, kind;
        void'($urandom(32'd1234));
        for (int c = 0; c < 8; c++) begin
            mhead[c] = 0;
            mcnt[c]  = 0;
        end
        rst_n = 1'b0;
        rx_push = '0; rx_byte = '0; rx_err = '0;
        rd_strobe = 1'b0; rd_addr = '0; rd_be = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(rd_valid == 1'b0, "R11", "rd_valid in reset", 64'(rd_valid), 64'd0);
        check(rd_data == 32'h0, "R11", "rd_data in reset", 64'(rd_data), 64'd0);
        check(rx_level == '0, "R11", "levels in reset", 64'(rx_level), 64'd0);
        rst_n = 1'b1;

        // R2 / R3: data window on channel 2 with partial drain, then empty lanes
        for (int i = 0; i < 5; i++) push1(2, 8'hA0 + 8'(i), 3'b000);
        rd(12'h500, 4'hF, "R2");
        rd(12'h53F, 4'h1, "R2");
        push1(2, 8'h5C, 3'b000);
        rd(12'h520, 4'hF, "R3");
        rd(12'h500, 4'hF, "R3");
        // R6: gap in enables on data window
        for (int i = 0; i < 3; i++) push1(2, 8'h30 + 8'(i), 3'b000);
        rd(12'h504, 4'b1010, "R6");
        rd(12'h508, 4'b0100, "R6");

        // R1 / R4: highest channel, paired window with error flags
        push1(7, 8'h11, 3'b001);
        push1(7, 8'h22, 3'b010);
        push1(7, 8'h33, 3'b100);
        rd(12'hF80, 4'hF, "R4");
        rd(12'hFFE, 4'b1100, "R6");
        rd(12'hFC0, 4'hF, "R5");
        push1(0, 8'h7E, 3'b111);
        rd(12'h1F0, 4'b0010, "R1");

        // R7: misses with data pending
        push1(3, 8'h99, 3'b000);
        rd(12'h740, 4'hF, "R7");
        rd(12'h600, 4'hF, "R7");
        rd(12'h7A0, 4'h3, "R1");

        // R9 / R10: overfill channel 0, then drain in 16 dword reads
        for (int i = 0; i < 70; i++) push1(0, 8'(i), 3'(i));
        for (int i = 0; i < 16; i++) rd(12'h100 + 12'(4 * i), 4'hF, "R10");
        idle();
        check(rx_level[6:0] == 7'd0, "R10", "level after drain", 64'(rx_level[6:0]), 64'd0);

        // R9: simultaneous push and pop on one channel
        push1(4, 8'hC1, 3'b000);
        step(8'h10, 64'(8'hC2) << 32, 24'h0, 1'b1, 12'h900, 4'h1, "R9");
        rd(12'h900, 4'hF, "R9");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            pv = 8'($urandom & $urandom);
            pd = {$urandom, $urandom};
            pe = 24'($urandom);
            ch = int'($urandom % 8);
            kind = int'($urandom % 8);
            if (kind < 4)      a = {3'(ch), 1'b1, 2'b00, 6'($urandom)};
            else if (kind < 7) a = {3'(ch), 1'b1, 1'b1, 7'($urandom)};
            else if ($urandom % 2 == 0) a = {3'(ch), 1'b1, 2'b01, 6'($urandom)};
            else               a = {3'(ch), 1'b0, 8'($urandom)};
            step(pv, pd, pe, 1'($urandom % 3 != 0), a, 4'($urandom), "");
        end
        idle();
        idle();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule